// File: doc/BRIEF.md
# Board Control and Status Register Bank

This block is a small register bank that sits in board-management logic behind a simple request/acknowledge register bus. It reports switch inputs, drives user LEDs and the serial-EEPROM write-protect line, combines a hardware switch and a software bit into a flash write-protect output, and chooses between the primary and alternate boot block. A keyed write issues a one-cycle hard-reset request to an external reset sequencer.

It also returns a fixed revision byte and a writable 32-bit build date code. A pair of test addresses lets software check the data bus. Both test addresses store the written word unchanged, but only one of them reads back the stored word; the other reads back its bitwise complement.

Every access runs through a three-state bus machine. `ST_IDLE` waits for `req`. The transition `GO_WRITE` (req with we high) enters `ST_WRITE`, and the transition `GO_READ` (req with we low) enters `ST_READ`. Both access states leave through `DONE` and return to `ST_IDLE` after one cycle. `ack` is high for the whole access cycle. A write takes effect at the clock edge that ends `ST_WRITE`.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset, eeprom_wp is 1, all LEDs are off, the software flash protect bit and the map override bit are 0, the date register holds parameter DATE_CODE, and the test register holds 0.
- R2: A req that is sampled in ST_IDLE produces ack high in the next cycle only, and that ack lasts exactly one cycle. A req that arrives while an access is in progress is ignored. rdata is 0 whenever ack is low.
- R3: A write to word 0 (control) with wdata[7:5] equal to 3'b101 raises hard_rst_req for exactly the ack cycle. Any other value in those bits gives no pulse. Bits 7:5 always read as 0.
- R4: Control bit 4 drives eeprom_wp, and control bit i (for i below N_LEDS) drives led[i], with 1 meaning on. These outputs change only at the end of a write cycle.
- R5: flash_wp is 1 when sw_flash_wp is 1 or when flash-register (word 1) bit 0 is 1. Word 1 reads the software bit in bit 0 and the switch in bit 1.
- R6: boot_alt_sel is 1 only when sw_boot_alt is 1 and the override bit (word 1, bit 2) is 0. Word 1 bit 3 reads the boot switch.
- R7: Word 2 reads parameter REV (default 0x01) in bits 7:0 and ignores writes.
- R8: Word 3 is a read/write date code, with year in bits 31:24, month in 23:16, day in 15:8 and version in 7:0.
- R9: A write to word 4 or word 5 stores the data unchanged. Word 4 reads the stored value, and word 5 reads its bitwise complement.
- R10: Reserved bits, and words 6 and 7, read as 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| ack | output | 1 | Access cycle, one clock wide |
| rdata | output | 32 | Read data, valid while ack |
| sw_flash_wp | input | 1 | Hardware flash protect switch |
| sw_boot_alt | input | 1 | Boot-block switch, 1 = alternate |
| led | output | N_LEDS | User LED drives, 1 = on |
| eeprom_wp | output | 1 | EEPROM write protect |
| flash_wp | output | 1 | Flash write protect |
| boot_alt_sel | output | 1 | Alternate boot block mapped on top |
| hard_rst_req | output | 1 | One-cycle hard-reset request |

## Verification
Two effects can occur in the same cycle. A single control write can carry the reset key in bits 7:5 and also change the LED and EEPROM-protect bits. The bench provokes this with directed writes of 0xA5 and 0xB0, and with random control writes, about one in eight of which carries the key.

Each such write is judged twice. The reset pulse is checked during the ack cycle. The LED and write-protect outputs, together with a read-back that must show the key bits as zero, are checked once the write has landed.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} bus_state_t;

    localparam int REG_AW = 3;
    localparam int DW     = 32;

    localparam logic [REG_AW-1:0] A_CTRL     = 3'd0;
    localparam logic [REG_AW-1:0] A_FLASH    = 3'd1;
    localparam logic [REG_AW-1:0] A_REV      = 3'd2;
    localparam logic [REG_AW-1:0] A_DATE     = 3'd3;
    localparam logic [REG_AW-1:0] A_TEST     = 3'd4;
    localparam logic [REG_AW-1:0] A_TEST_INV = 3'd5;

    localparam int          KEY_LSB   = 5;
    localparam logic [2:0]  RESET_KEY = 3'b101;
    localparam int          EEWP_BIT  = 4;
    localparam int          FL_SWWP   = 0;
    localparam int          FL_HWWP   = 1;
    localparam int          FL_OVR    = 2;
    localparam int          FL_BOOTSW = 3;
endpackage

// File: rtl/board_ctl_fsm.sv
module board_ctl_fsm
    import board_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic              ack,
    output logic              wr_en,
    output logic              rd_en,
    output logic [REG_AW-1:0] hold_addr,
    output logic [DW-1:0]     hold_wdata
);
    bus_state_t state, state_nx;

    // Transitions: GO_WRITE, GO_READ, DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req) state_nx = we ? ST_WRITE : ST_READ;
            ST_WRITE: state_nx = ST_IDLE;
            ST_READ:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if (state == ST_IDLE && req) begin
            hold_addr  <= addr;
            hold_wdata <= wdata;
        end
    end

    always_comb begin
        ack   = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WRITE: begin ack = 1'b1; wr_en = 1'b1; end
            ST_READ:  begin ack = 1'b1; rd_en = 1'b1; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/board_ctl_store.sv
module board_ctl_store
    import board_ctl_pkg::*;
#(
    parameter int          N_LEDS    = 3,
    parameter logic [7:0]  REV       = 8'h01,
    parameter logic [31:0] DATE_CODE = 32'h2406_1503
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              sw_flash_wp,
    input  logic              sw_boot_alt,
    output logic [DW-1:0]     rdata,
    output logic [N_LEDS-1:0] led,
    output logic              eeprom_wp,
    output logic              flash_wp,
    output logic              boot_alt_sel,
    output logic              hard_rst_req
);
    localparam int KEY_W = 3;

    logic          sw_wp_q, ovr_q;
    logic [DW-1:0] date_q, test_q;
    logic          wr_ctrl, wr_flash;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_flash = wr_en && (addr == A_FLASH);

    for (genvar i = 0; i < N_LEDS; i++) begin : g_led
        always_ff @(posedge clk) begin
            if (!rst_n)       led[i] <= 1'b0;
            else if (wr_ctrl) led[i] <= wdata[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eeprom_wp <= 1'b1;
            sw_wp_q   <= 1'b0;
            ovr_q     <= 1'b0;
            date_q    <= DATE_CODE;
            test_q    <= '0;
        end else if (wr_en) begin
            if (wr_ctrl) eeprom_wp <= wdata[EEWP_BIT];
            if (wr_flash) begin
                sw_wp_q <= wdata[FL_SWWP];
                ovr_q   <= wdata[FL_OVR];
            end
            if (addr == A_DATE) date_q <= wdata;
            if (addr == A_TEST || addr == A_TEST_INV) test_q <= wdata;
        end
    end

    assign hard_rst_req = wr_ctrl && (wdata[KEY_LSB +: KEY_W] == RESET_KEY);
    assign flash_wp     = sw_flash_wp | sw_wp_q;
    assign boot_alt_sel = sw_boot_alt & ~ovr_q;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL: begin
                    rdata[N_LEDS-1:0] = led;
                    rdata[EEWP_BIT]   = eeprom_wp;
                end
                A_FLASH: begin
                    rdata[FL_SWWP]   = sw_wp_q;
                    rdata[FL_HWWP]   = sw_flash_wp;
                    rdata[FL_OVR]    = ovr_q;
                    rdata[FL_BOOTSW] = sw_boot_alt;
                end
                A_REV:      rdata[7:0] = REV;
                A_DATE:     rdata = date_q;
                A_TEST:     rdata = test_q;
                A_TEST_INV: rdata = ~test_q;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int          N_LEDS    = 3,
    parameter logic [7:0]  REV       = 8'h01,
    parameter logic [31:0] DATE_CODE = 32'h2406_1503
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output logic              ack,
    output logic [31:0]       rdata,
    input  logic              sw_flash_wp,
    input  logic              sw_boot_alt,
    output logic [N_LEDS-1:0] led,
    output logic              eeprom_wp,
    output logic              flash_wp,
    output logic              boot_alt_sel,
    output logic              hard_rst_req
);
    logic              wr_en, rd_en;
    logic [REG_AW-1:0] hold_addr;
    logic [DW-1:0]     hold_wdata;

    board_ctl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .wr_en(wr_en), .rd_en(rd_en),
        .hold_addr(hold_addr), .hold_wdata(hold_wdata)
    );

    board_ctl_store #(.N_LEDS(N_LEDS), .REV(REV), .DATE_CODE(DATE_CODE)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(hold_addr), .wdata(hold_wdata),
        .sw_flash_wp(sw_flash_wp), .sw_boot_alt(sw_boot_alt),
        .rdata(rdata), .led(led), .eeprom_wp(eeprom_wp), .flash_wp(flash_wp),
        .boot_alt_sel(boot_alt_sel), .hard_rst_req(hard_rst_req)
    );
endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ack,
    input logic [31:0] rdata,
    input logic        hard_rst_req,
    input logic        eeprom_wp,
    input logic        flash_wp,
    input logic        sw_flash_wp,
    input logic        boot_alt_sel,
    input logic        sw_boot_alt
);
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r2_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> rdata == 32'd0);
    a_r3_pulse_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst_req |-> ack);
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst_req |=> !hard_rst_req);
    a_r4_eewp_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> $stable(eeprom_wp));
    a_r5_hw_protects: assert property (@(posedge clk) disable iff (!rst_n)
        sw_flash_wp |-> flash_wp);
    a_r6_switch_off_primary: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_boot_alt |-> !boot_alt_sel);
endmodule

bind board_ctl_regs board_ctl_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .rdata(rdata),
    .hard_rst_req(hard_rst_req), .eeprom_wp(eeprom_wp), .flash_wp(flash_wp),
    .sw_flash_wp(sw_flash_wp), .boot_alt_sel(boot_alt_sel), .sw_boot_alt(sw_boot_alt)
);

// File: tb/board_ctl_regs_bench.sv
module board_ctl_regs_bench;
    localparam int          NL   = 3;
    localparam logic [31:0] DATE = 32'h2406_1503;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic sw_flash_wp = 1'b0, sw_boot_alt = 1'b0;
    logic ack, eeprom_wp, flash_wp, boot_alt_sel, hard_rst_req;
    logic [31:0] rdata;
    logic [NL-1:0] led;

    always #2.5 clk = ~clk;

    board_ctl_regs u_board_ctl_regs (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .sw_flash_wp(sw_flash_wp), .sw_boot_alt(sw_boot_alt),
        .led(led), .eeprom_wp(eeprom_wp), .flash_wp(flash_wp),
        .boot_alt_sel(boot_alt_sel), .hard_rst_req(hard_rst_req)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model state
    logic [NL-1:0] m_led = '0;
    logic m_eewp = 1'b1, m_swwp = 1'b0, m_ovr = 1'b0;
    logic [31:0] m_date = DATE, m_test = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [31:0] v = '0;
        case (a)
            3'd0: begin v[NL-1:0] = m_led; v[4] = m_eewp; end
            3'd1: begin v[0] = m_swwp; v[1] = sw_flash_wp; v[2] = m_ovr; v[3] = sw_boot_alt; end
            3'd2: v = 32'h01;
            3'd3: v = m_date;
            3'd4: v = m_test;
            3'd5: v = ~m_test;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [31:0] d);
        case (a)
            3'd0: begin m_led = d[NL-1:0]; m_eewp = d[4]; end
            3'd1: begin m_swwp = d[0]; m_ovr = d[2]; end
            3'd3: m_date = d;
            3'd4, 3'd5: m_test = d;
            default: ;
        endcase
    endtask

    task automatic check_outputs();
        chk(led == m_led, "R4 led", 32'(led), 32'(m_led));
        chk(eeprom_wp == m_eewp, "R4 eeprom_wp", 32'(eeprom_wp), 32'(m_eewp));
        chk(flash_wp == (sw_flash_wp | m_swwp), "R5 flash_wp", 32'(flash_wp), 32'(sw_flash_wp | m_swwp));
        chk(boot_alt_sel == (sw_boot_alt & ~m_ovr), "R6 boot_alt_sel", 32'(boot_alt_sel), 32'(sw_boot_alt & ~m_ovr));
    endtask

    // one access; checks ack, rdata or pulse, then outputs after commit
    task automatic access(input bit w, input logic [2:0] a, input logic [31:0] d);
        logic [31:0] er;
        bit ep;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        chk(ack == 1'b0, "R2 no ack before edge", 32'(ack), 0);
        @(negedge clk);
        req = 1'b0;
        chk(ack == 1'b1, "R2 ack after req", 32'(ack), 1);
        if (w) begin
            ep = (a == 3'd0) && (d[7:5] == 3'b101);
            chk(hard_rst_req == ep, "R3 reset pulse", 32'(hard_rst_req), 32'(ep));
            model_write(a, d);
        end else begin
            er = exp_read(a);
            chk(rdata == er, "R7 R8 R9 R10 read data", rdata, er);
            chk(hard_rst_req == 1'b0, "R3 no pulse on read", 32'(hard_rst_req), 0);
        end
        @(negedge clk);
        chk(ack == 1'b0 && rdata == 0, "R2 ack one cycle", 32'(ack), 0);
        chk(hard_rst_req == 1'b0, "R3 pulse one cycle", 32'(hard_rst_req), 0);
        check_outputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(eeprom_wp == 1'b1, "R1 eeprom_wp reset", 32'(eeprom_wp), 1);
        chk(led == '0, "R1 led reset", 32'(led), 0);
        chk(flash_wp == 1'b0, "R1 flash_wp reset", 32'(flash_wp), 0);
        chk(ack == 1'b0 && hard_rst_req == 1'b0, "R1 idle", 32'(ack), 0);
        access(1'b0, 3'd3, 0);      // R1 date default
        access(1'b0, 3'd4, 0);      // R1 test zero
        access(1'b0, 3'd2, 0);      // R7 revision
        access(1'b1, 3'd2, 32'hFFFF_FFFF);
        access(1'b0, 3'd2, 0);      // R7 write ignored
        // R3 with R4 in the same write
        access(1'b1, 3'd0, 32'h0000_00A5);
        access(1'b0, 3'd0, 0);      // key reads 0
        access(1'b1, 3'd0, 32'h0000_0083);  // key 100: no pulse
        access(1'b1, 3'd0, 32'h0000_00B0);  // key 101, eewp on
        // R5 / R6
        sw_flash_wp = 1'b1; sw_boot_alt = 1'b1;
        access(1'b0, 3'd1, 0);
        access(1'b1, 3'd1, 32'h0000_0004);  // override
        sw_flash_wp = 1'b0;
        access(1'b1, 3'd1, 32'h0000_0001);  // sw protect
        access(1'b0, 3'd1, 0);
        // R8 date fields, R9 test pair
        access(1'b1, 3'd3, 32'h2512_3107);
        access(1'b0, 3'd3, 0);
        access(1'b1, 3'd5, 32'h5A5A_0FF0);
        access(1'b0, 3'd4, 0);
        access(1'b0, 3'd5, 0);
        // R10 unmapped
        access(1'b1, 3'd6, 32'hDEAD_BEEF);
        access(1'b0, 3'd6, 0);
        access(1'b0, 3'd7, 0);
        access(1'b1, 3'd1, 32'hFFFF_FFF0);  // reserved bits ignored
        access(1'b0, 3'd1, 0);
        // R2 request during busy cycle is ignored
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 3'd2;
        @(negedge clk);
        chk(ack == 1'b1, "R2 first ack", 32'(ack), 1);
        @(negedge clk);
        req = 1'b0;
        chk(ack == 1'b0, "R2 busy req ignored", 32'(ack), 0);
        @(negedge clk);
        // random mix
        for (int k = 0; k < 400; k++) begin
            sw_flash_wp = $urandom_range(0, 1);
            sw_boot_alt = $urandom_range(0, 1);
            access($urandom_range(0, 1), 3'($urandom_range(0, 7)), $urandom());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule